// File: doc/BRIEF.md
# Two-Byte Buffered SPI-to-Serial-Bus Bridge

This block sits between a host that is SPI master and a slower asynchronous serial bus shared by several nodes. The host clocks a 16-bit word into an internal buffer over SPI at its own rate. It then asks the block to send that word by pulling the request line low. The block takes ownership of the buffer and waits for the bus to become idle. It then puts both bytes on the bus as asynchronous frames, one bit per bus bit tick.

Each bus frame has a low start bit, eight data bits with the least significant bit first, and a high stop bit. While a frame goes out, the block captures the level it reads back from the bus. Each buffered byte is overwritten by its read-back byte, so after a send the host's next SPI transfer returns what the bus actually carried. Ownership returns to the host at the tick that ends the second stop bit.

Host SCK, MOSI, CS and the request line are synchronised into the block clock domain. Bus bit timing comes in from outside as a one-cycle `bit_tick` strobe. The transceiver is outside this block.

Top module: `dbb_bus_buffer`

## Requirements
- R1: After reset the block releases ownership (`ctl_own_n` = 1), drives `bus_tx` high, and the buffer holds 0x0000.
- R2: A host transfer of exactly 16 SCK rising edges while `spi_cs_n` is low, ending with `spi_cs_n` rising, replaces the buffer with the 16 MOSI bits, first bit in bit 15. During the same transfer `spi_miso` presents the previous buffer contents, bit 15 first, each bit valid before the rising edge that shifts it.
- R3: A host transfer that ends after any number of rising edges other than 16 leaves the buffer unchanged.
- R4: A falling edge on `ctl_req_n` while the host owns the buffer makes the block take ownership and drive `ctl_own_n` low within 6 clock cycles.
- R5: While the block owns the buffer and `bus_idle` is low, `bus_tx` stays high whatever `bit_tick` does. The first frame starts on the first `bit_tick` seen with `bus_idle` high.
- R6: The two frames follow each other with no gap, one bit per `bit_tick` period. Buffer bits 15..8 go out first. Each frame is a 0 start bit, then data bits least significant first, then a 1 stop bit.
- R7: After a send, each buffer byte holds the eight data bits read on `bus_rx` during its frame. The level is sampled at the `bit_tick` that ends each data bit.
- R8: `ctl_own_n` stays low through both frames and returns high at the `bit_tick` that ends the second stop bit.
- R9: While the block owns the buffer, SCK edges and CS edges from the host neither shift nor commit buffer data.
- R10: `spi_miso_oe` is low whenever `spi_cs_n` is high and high whenever it is low. `ctl_own_n` is driven at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Host select, active low; high floats the host data pins |
| spi_sck | input | 1 | Host shift clock; data is captured on its rising edge |
| spi_mosi | input | 1 | Host data into the buffer |
| spi_miso | output | 1 | Buffer data out to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso` |
| ctl_req_n | input | 1 | Host send request; its falling edge starts a send |
| ctl_own_n | output | 1 | Low while the block owns the buffer |
| bus_idle | input | 1 | Bus idle indication from the bus monitor |
| bit_tick | input | 1 | One-cycle strobe per bus bit time |
| bus_rx | input | 1 | Level read back from the bus |
| bus_tx | output | 1 | Bit driven onto the bus, high when quiet |

## Verification
A wrong ownership state shows on `ctl_own_n` within a few cycles of the request edge. It also shows as a `bus_tx` level that breaks the frame at the very next bit tick. A wrong bit or byte index in the frame sequencer shows as a wrong `bus_tx` bit in the same tick period. A wrong write-back or a lost transfer count does not show on the bus. It appears only on the next host transfer, where `spi_miso` returns a word that differs from the one expected. The bench therefore reads the buffer back after every send and after every partial or blocked transfer.

// File: rtl/dbb_pkg.sv
package dbb_pkg;

    localparam int BYTE_W     = 8;
    localparam int NBYTES     = 2;
    localparam int BUF_W      = BYTE_W * NBYTES;
    localparam int FRAME_BITS = BYTE_W + 2;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int BIDX_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    typedef enum logic [1:0] {
        ST_HOST = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } own_state_e;

    typedef struct packed {
        logic [BIDX_W-1:0] byte_idx;
        logic [BIT_W-1:0]  bit_idx;
    } frame_pos_t;

endpackage

// File: rtl/dbb_sync.sv
module dbb_sync #(
    parameter int          W      = 4,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= RST_V;
            q    <= RST_V;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dbb_host_shift.sv
module dbb_host_shift #(
    parameter int BUF_W = dbb_pkg::BUF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_s,
    input  logic             cs_n_s,
    input  logic             mosi_s,
    input  logic             owned,
    input  logic [BUF_W-1:0] buf_q,
    output logic             miso_bit,
    output logic             load_en,
    output logic [BUF_W-1:0] load_data
);
    localparam int CNT_W = $clog2(BUF_W + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_W);

    logic             sck_d, cs_d;
    logic [BUF_W-1:0] sh;
    logic [CNT_W-1:0] cnt;
    logic             sck_rise, cs_fall, cs_rise;

    assign sck_rise = sck_s & ~sck_d;
    assign cs_fall  = ~cs_n_s & cs_d;
    assign cs_rise  = cs_n_s & ~cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
            sh    <= '0;
            cnt   <= '0;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
            if (owned) begin
                cnt <= CNT_MAX;
            end else if (cs_fall) begin
                sh  <= buf_q;
                cnt <= '0;
            end else if (!cs_n_s && sck_rise) begin
                sh <= {sh[BUF_W-2:0], mosi_s};
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            end
        end
    end

    assign miso_bit  = sh[BUF_W-1];
    assign load_en   = cs_rise && !owned && (cnt == CNT_FULL);
    assign load_data = sh;

    AST_NO_SHIFT_WHILE_OWNED: assert property (@(posedge clk) disable iff (rst)
        (owned && $past(owned)) |-> $stable(sh)); // R9

    AST_LOAD_ONLY_ON_FULL: assert property (@(posedge clk) disable iff (rst)
        load_en |-> ($past(cnt) == CNT_FULL || cnt == CNT_FULL)); // R3
endmodule

// File: rtl/dbb_frame_engine.sv
module dbb_frame_engine
    import dbb_pkg::*;
#(
    parameter int E_BYTE_W = BYTE_W,
    parameter int E_NBYTES = NBYTES
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_fall,
    input  logic                         bus_idle,
    input  logic                         bit_tick,
    input  logic                         bus_rx,
    input  logic                         load_en,
    input  logic [E_BYTE_W*E_NBYTES-1:0] load_data,
    output logic [E_BYTE_W*E_NBYTES-1:0] buf_q,
    output logic                         owned,
    output logic                         bus_tx
);
    localparam int EBUF_W  = E_BYTE_W * E_NBYTES;
    localparam int EFRAME  = E_BYTE_W + 2;
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(EFRAME - 1);
    localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(E_NBYTES - 1);

    own_state_e            state;
    frame_pos_t            pos;
    logic [E_BYTE_W-1:0]   rx_sh;
    logic [E_BYTE_W-1:0]   byte_v [E_NBYTES];
    logic [E_BYTE_W-1:0]   cur_byte;
    logic                  frame_bit;

    for (genvar g = 0; g < E_NBYTES; g++) begin : g_bytes
        assign byte_v[g] = buf_q[EBUF_W-1-g*E_BYTE_W -: E_BYTE_W];
    end

    assign cur_byte = byte_v[pos.byte_idx];

    always_comb begin
        frame_bit = 1'b1;
        if (pos.bit_idx == '0) frame_bit = 1'b0;
        for (int i = 0; i < E_BYTE_W; i++) begin
            if (pos.bit_idx == BIT_W'(i + 1)) frame_bit = cur_byte[i];
        end
    end

    assign bus_tx = (state == ST_SEND) ? frame_bit : 1'b1;
    assign owned  = (state != ST_HOST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOST;
            pos   <= '0;
            rx_sh <= '0;
            buf_q <= '0;
        end else begin
            case (state)
                ST_HOST: begin
                    if (load_en)  buf_q <= load_data;
                    if (req_fall) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (bus_idle && bit_tick) begin
                        state <= ST_SEND;
                        pos   <= '0;
                    end
                end
                ST_SEND: begin
                    if (bit_tick) begin
                        if (pos.bit_idx != '0 && pos.bit_idx != LAST_BIT)
                            rx_sh <= {bus_rx, rx_sh[E_BYTE_W-1:1]};
                        if (pos.bit_idx == LAST_BIT) begin
                            for (int k = 0; k < E_NBYTES; k++) begin
                                if (pos.byte_idx == BIDX_W'(k))
                                    buf_q[EBUF_W-1-k*E_BYTE_W -: E_BYTE_W] <= rx_sh;
                            end
                            pos.bit_idx <= '0;
                            if (pos.byte_idx == LAST_BYTE) begin
                                state        <= ST_HOST;
                                pos.byte_idx <= '0;
                            end else begin
                                pos.byte_idx <= pos.byte_idx + 1'b1;
                            end
                        end else begin
                            pos.bit_idx <= pos.bit_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_HOST;
            endcase
        end
    end

    AST_BUF_HELD: assert property (@(posedge clk) disable iff (rst)
        (!owned && !load_en) |=> $stable(buf_q)); // R3

    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_tx) && $past(state == ST_WAIT)) |-> $past(bus_idle && bit_tick)); // R5
endmodule

// File: rtl/dbb_bus_buffer.sv
module dbb_bus_buffer
    import dbb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe,
    input  logic ctl_req_n,
    output logic ctl_own_n,
    input  logic bus_idle,
    input  logic bit_tick,
    input  logic bus_rx,
    output logic bus_tx
);
    logic [3:0]       sync_q;
    logic             cs_n_s, sck_s, mosi_s, req_n_s, req_d, req_fall;
    logic             owned, load_en, miso_bit;
    logic [BUF_W-1:0] buf_q, load_data;

    dbb_sync #(.W(4), .RST_V(4'b1001)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_cs_n, spi_sck, spi_mosi, ctl_req_n}),
        .q   (sync_q)
    );

    assign {cs_n_s, sck_s, mosi_s, req_n_s} = sync_q;

    always_ff @(posedge clk) begin
        if (rst) req_d <= 1'b1;
        else     req_d <= req_n_s;
    end

    assign req_fall = req_d & ~req_n_s;

    dbb_host_shift #(.BUF_W(BUF_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .sck_s     (sck_s),
        .cs_n_s    (cs_n_s),
        .mosi_s    (mosi_s),
        .owned     (owned),
        .buf_q     (buf_q),
        .miso_bit  (miso_bit),
        .load_en   (load_en),
        .load_data (load_data)
    );

    dbb_frame_engine #(.E_BYTE_W(BYTE_W), .E_NBYTES(NBYTES)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .req_fall  (req_fall),
        .bus_idle  (bus_idle),
        .bit_tick  (bit_tick),
        .bus_rx    (bus_rx),
        .load_en   (load_en),
        .load_data (load_data),
        .buf_q     (buf_q),
        .owned     (owned),
        .bus_tx    (bus_tx)
    );

    assign spi_miso_oe = ~spi_cs_n;
    assign spi_miso    = spi_miso_oe ? miso_bit : 1'b0;
    assign ctl_own_n   = ~owned;

    AST_TX_QUIET_WHEN_RELEASED: assert property (@(posedge clk) disable iff (rst)
        ctl_own_n |-> bus_tx); // R5

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_own_n) |-> ($past(bus_tx) && $past(bit_tick))); // R8

    AST_TAKE_ONLY_ON_REQUEST: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_own_n) |-> $past(req_fall)); // R4
endmodule

// File: tb/dbb_bus_buffer_tb.sv
module dbb_bus_buffer_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic ctl_req_n = 1'b1, bus_idle = 1'b0, bit_tick = 1'b0, bus_rx = 1'b1;
    logic spi_miso, spi_miso_oe, ctl_own_n, bus_tx;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbb_bus_buffer u_dut (
        .clk (clk), .rst (rst),
        .spi_cs_n (spi_cs_n), .spi_sck (spi_sck), .spi_mosi (spi_mosi),
        .spi_miso (spi_miso), .spi_miso_oe (spi_miso_oe),
        .ctl_req_n (ctl_req_n), .ctl_own_n (ctl_own_n),
        .bus_idle (bus_idle), .bit_tick (bit_tick),
        .bus_rx (bus_rx), .bus_tx (bus_tx)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_frame_bit(input logic [15:0] w, input int b);
        logic [7:0] byt;
        int p;
        byt = (b < 10) ? w[15:8] : w[7:0];
        p = b % 10;
        if (p == 0) return 1'b0;
        if (p == 9) return 1'b1;
        return byt[p-1];
    endfunction

    task automatic spi_xfer(input logic [15:0] wr, input int nbits, output logic [15:0] rd);
        rd = '0;
        spi_cs_n = 1'b0;
        wait_clk(6);
        chk(spi_miso_oe == 1'b1, "R10 oe while selected", 32'(spi_miso_oe), 32'h1);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = wr[15 - (i % 16)];
            wait_clk(4);
            if (i < 16) rd[15-i] = spi_miso;
            spi_sck = 1'b1;
            wait_clk(4);
            spi_sck = 1'b0;
        end
        wait_clk(4);
        spi_cs_n = 1'b1;
        wait_clk(6);
        chk(spi_miso_oe == 1'b0, "R10 oe while deselected", 32'(spi_miso_oe), 32'h0);
    endtask

    task automatic tick;
        @(negedge clk) bit_tick = 1'b1;
        @(negedge clk) bit_tick = 1'b0;
        wait_clk(3);
    endtask

    task automatic run_send(input logic [15:0] word, input logic [15:0] jam, input bit blocked_xfer);
        logic [15:0] junk;
        logic [15:0] rd;
        ctl_req_n = 1'b0;
        wait_clk(6);
        chk(ctl_own_n == 1'b0, "R4 ownership taken", 32'(ctl_own_n), 32'h0);
        ctl_req_n = 1'b1;
        bus_idle = 1'b0;
        for (int t = 0; t < 3; t++) begin
            tick();
            chk(bus_tx == 1'b1, "R5 holds while bus busy", 32'(bus_tx), 32'h1);
        end
        if (blocked_xfer) spi_xfer(16'($urandom), 16, junk);
        chk(ctl_own_n == 1'b0, "R9 still owned after blocked transfer", 32'(ctl_own_n), 32'h0);
        bus_idle = 1'b1;
        tick();
        bus_idle = 1'b0;
        for (int b = 0; b < 20; b++) begin
            logic e;
            int p;
            e = exp_frame_bit(word, b);
            p = b % 10;
            chk(bus_tx == e, $sformatf("R6 frame bit %0d", b), 32'(bus_tx), 32'(e));
            if (p >= 1 && p <= 8)
                bus_rx = e & ((b < 10) ? jam[8 + p - 1] : jam[p - 1]);
            else
                bus_rx = e;
            if (b == 19)
                chk(ctl_own_n == 1'b0, "R8 held through last stop", 32'(ctl_own_n), 32'h0);
            tick();
        end
        bus_rx = 1'b1;
        chk(ctl_own_n == 1'b1, "R8 released after second stop", 32'(ctl_own_n), 32'h1);
        chk(bus_tx == 1'b1, "R5 quiet after release", 32'(bus_tx), 32'h1);
        spi_xfer(word & jam, 16, rd);
        chk(rd == (word & jam), blocked_xfer ? "R9 R7 read-back not overwritten" : "R7 read-back stored",
            32'(rd), 32'(word & jam));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rd, a, b, c, d, j;
        void'($urandom(32'd1234));
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);

        chk(ctl_own_n == 1'b1, "R1 released at reset", 32'(ctl_own_n), 32'h1);
        chk(bus_tx == 1'b1, "R1 bus quiet at reset", 32'(bus_tx), 32'h1);
        chk(spi_miso_oe == 1'b0, "R10 oe at reset", 32'(spi_miso_oe), 32'h0);

        a = 16'hA5C3;
        spi_xfer(a, 16, rd);
        chk(rd == 16'h0000, "R1 buffer zero after reset", 32'(rd), 32'h0);
        b = 16'($urandom);
        spi_xfer(b, 16, rd);
        chk(rd == a, "R2 full transfer commits", 32'(rd), 32'(a));

        c = ~b;
        spi_xfer(c, 9, rd);
        spi_xfer(c, 17, rd);
        spi_xfer(16'h0F0F, 0, rd);
        d = 16'($urandom);
        spi_xfer(d, 16, rd);
        chk(rd == b, "R3 short and long transfers ignored", 32'(rd), 32'(b));

        run_send(d, 16'hFFFF, 1'b0);

        for (int r = 0; r < 4; r++) begin
            a = 16'($urandom);
            j = (r == 0) ? 16'hFFFF : 16'($urandom);
            spi_xfer(a, 16, rd);
            run_send(a, j, (r % 2) == 1);
        end

        a = 16'h8001;
        spi_xfer(a, 16, rd);
        run_send(a, 16'h7FFE, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule